// File: doc/BRIEF.md
# Event Status and Mask Interrupt Aggregator

This block collects 96 single-cycle event pulses from peripherals into sticky status bits, arranged as three 32-bit status words. There is one shared set of status bits. Each of three interrupt outputs has its own full 96-bit enable mask. Every output is a level signal that stays high while any status bit enabled on that output remains set. Software acknowledges an event by writing a one to its status bit. It can find the lowest-numbered pending enabled event for any output by reading a per-output pending register.

Software reaches all registers through a simple word-addressed register bus. A write takes effect on the rising clock edge where `bus_wr_i` is high. A read is combinational: `bus_rdata_o` follows `bus_addr_i` whenever no write is in flight. The register map is fixed: status words at 0x00/0x04/0x08, mask groups at 0x10/0x20/0x30 (word k at +4·k), and pending registers at 0x40/0x44/0x48. Output A (`irq_o[0]`) has the highest priority, then B (`irq_o[1]`), then C (`irq_o[2]`).

The decode is plain combinational logic. No control state machine sits in the path: each register acts on the bus strobe in the cycle it arrives.

Top module: `evt_aggr_top`

## Requirements
- R1: While reset is asserted, and right after it is released, every status, mask and pending register reads 0 and `irq_o` is 0.
- R2: A one on `evt_i[n]` in a cycle sets status bit n (word n/32, bit n%32) at that clock edge, and the bit stays set until it is acknowledged.
- R3: A write to status word k (address 4·k, k in 0..2) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Mask register word k of output g lives at address 0x10·(g+1)+4·k. It is read/write and returns the last value written.
- R6: `irq_o[g]` is high exactly when some status bit is set while the same bit of mask group g is 1. It falls once every such bit is acknowledged or masked.
- R7: The three outputs are independent. An event enabled only in group g raises only `irq_o[g]`.
- R8: The pending register for output g at 0x40+4·g returns bit 7 = 1 and bits 6:0 = the lowest index n with status n and mask-g bit n both set. It returns 0 when there is no such n.
- R9: Reads of unmapped or misaligned addresses return 0. Writes to them, and to the pending registers, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 96 | Event pulses, bit n is event n |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 8 | Byte address of a 32-bit word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_o | output | 3 | Level interrupt outputs; bit 0 is A (highest), bit 2 is C |

## Verification
The assertions assume that `evt_i`, `bus_wr_i`, `bus_addr_i` and `bus_wdata_i` hold known values at every clock edge, and that reset is asserted from time zero. The sticky-status and no-spurious-clear properties rely on no write reaching a status word unless the strobe is high. The bench drives every input on the falling edge, holds reset low from the first instant, and clears the strobe and event lines after each cycle. The reference model therefore sees the same values the design samples.

// File: rtl/evt_aggr_pkg.sv
package evt_aggr_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 3;
    localparam int NUM_LINES = 3;
    localparam int EVENTS    = WORD_W * NUM_WORDS;
    localparam int IDX_W     = $clog2(EVENTS);
    localparam int ADDR_W    = 8;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_STAT = 2'd1,
        REG_MASK = 2'd2,
        REG_PEND = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] grp;
        logic [1:0] word;
    } reg_sel_t;

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
    import evt_aggr_pkg::*;
#(
    parameter int N_WORDS = NUM_WORDS,
    parameter int N_LINES = NUM_LINES
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam logic [3:0] LAST_MASK_HI = 4'(N_LINES);
    localparam logic [3:0] PEND_HI      = 4'(N_LINES + 1);
    localparam logic [1:0] WORD_LIM     = 2'(N_WORDS);
    localparam logic [1:0] LINE_LIM     = 2'(N_LINES);

    logic [3:0] hi;
    logic [1:0] wsel;
    logic [3:0] grp_full;

    assign hi       = addr[7:4];
    assign wsel     = addr[3:2];
    assign grp_full = hi - 4'd1;

    always_comb begin
        sel.kind = REG_NONE;
        sel.grp  = 2'd0;
        sel.word = 2'd0;
        if (addr[1:0] == 2'b00) begin
            if (hi == 4'd0 && wsel < WORD_LIM) begin
                sel.kind = REG_STAT;
                sel.word = wsel;
            end else if (hi >= 4'd1 && hi <= LAST_MASK_HI && wsel < WORD_LIM) begin
                sel.kind = REG_MASK;
                sel.grp  = grp_full[1:0];
                sel.word = wsel;
            end else if (hi == PEND_HI && wsel < LINE_LIM) begin
                sel.kind = REG_PEND;
                sel.grp  = wsel;
            end
        end
    end

endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
    parameter int W_W     = 32,
    parameter int N_WORDS = 3,
    localparam int NEV    = W_W * N_WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NEV-1:0]     evt_i,
    input  logic [N_WORDS-1:0] clr_we,
    input  logic [W_W-1:0]     wdata,
    output logic [NEV-1:0]     status_o
);

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic [W_W-1:0] word_q;
        logic [W_W-1:0] clr_bits;

        assign clr_bits = clr_we[w] ? wdata : '0;

        // Pulses are ORed in after the clear, so a same-cycle set survives.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= (word_q & ~clr_bits) | evt_i[w*W_W +: W_W];
            end
        end

        assign status_o[w*W_W +: W_W] = word_q;
    end

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
    parameter int W_W     = 32,
    parameter int N_WORDS = 3,
    parameter int N_LINES = 3,
    localparam int NEV    = W_W * N_WORDS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LINES*N_WORDS-1:0] we,
    input  logic [W_W-1:0]             wdata,
    output logic [N_LINES*NEV-1:0]     mask_o
);

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        for (genvar w = 0; w < N_WORDS; w++) begin : g_word
            logic [W_W-1:0] mword_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mword_q <= '0;
                end else if (we[l*N_WORDS + w]) begin
                    mword_q <= wdata;
                end
            end

            assign mask_o[l*NEV + w*W_W +: W_W] = mword_q;
        end
    end

endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
    parameter int N  = 96,
    parameter int IW = 7
) (
    input  logic [N-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        // Walk downward so the lowest set position is written last.
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign valid = |vec;

endmodule

// File: rtl/evt_aggr_top.sv
module evt_aggr_top
    import evt_aggr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVENTS-1:0]    evt_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);

    localparam int MASK_BITS = NUM_LINES * EVENTS;

    reg_sel_t                      sel;
    logic [NUM_WORDS-1:0]          stat_we;
    logic [NUM_LINES*NUM_WORDS-1:0] mask_we;
    logic [EVENTS-1:0]             status_q;
    logic [MASK_BITS-1:0]          mask_q;
    logic [NUM_LINES-1:0]          pend_vld;
    logic [NUM_LINES*IDX_W-1:0]    pend_idx;

    evt_addr_dec #(
        .N_WORDS(NUM_WORDS),
        .N_LINES(NUM_LINES)
    ) u_dec (
        .addr(bus_addr_i),
        .sel (sel)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_stat_we
        assign stat_we[w] = bus_wr_i && (sel.kind == REG_STAT) && (sel.word == 2'(w));
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_mask_we_l
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask_we_w
            assign mask_we[l*NUM_WORDS + w] = bus_wr_i && (sel.kind == REG_MASK)
                                              && (sel.grp == 2'(l)) && (sel.word == 2'(w));
        end
    end

    evt_status_bank #(
        .W_W    (WORD_W),
        .N_WORDS(NUM_WORDS)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_we  (stat_we),
        .wdata   (bus_wdata_i),
        .status_o(status_q)
    );

    evt_mask_bank #(
        .W_W    (WORD_W),
        .N_WORDS(NUM_WORDS),
        .N_LINES(NUM_LINES)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (bus_wdata_i),
        .mask_o(mask_q)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [EVENTS-1:0] hits;
        assign hits     = status_q & mask_q[l*EVENTS +: EVENTS];
        assign irq_o[l] = |hits;

        evt_prio_enc #(
            .N (EVENTS),
            .IW(IDX_W)
        ) u_enc (
            .vec  (hits),
            .valid(pend_vld[l]),
            .idx  (pend_idx[l*IDX_W +: IDX_W])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (sel.kind)
            REG_STAT: bus_rdata_o = status_q[int'(sel.word)*WORD_W +: WORD_W];
            REG_MASK: bus_rdata_o = mask_q[int'(sel.grp)*EVENTS + int'(sel.word)*WORD_W +: WORD_W];
            REG_PEND: begin
                bus_rdata_o[IDX_W]     = pend_vld[sel.grp];
                bus_rdata_o[IDX_W-1:0] = pend_idx[int'(sel.grp)*IDX_W +: IDX_W];
            end
            REG_NONE: bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/evt_aggr_chk.sv
module evt_aggr_chk #(
    parameter int EV  = 96,
    parameter int NL  = 3,
    parameter int WW  = 32,
    parameter int AW  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EV-1:0]    evt,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [WW-1:0]    bus_wdata,
    input logic [NL-1:0]    irq,
    input logic [EV-1:0]    status,
    input logic [NL*EV-1:0] mask,
    input logic [NL-1:0]    pend_vld
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == '0));

    // Covers R4 as well: a pulse is never lost, even beside a clearing write.
    p_evt_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    p_no_spurious_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((status & $past(status)) == $past(status)));

    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h10) |=> (mask[WW-1:0] == $past(bus_wdata)));

    p_pend_matches_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld == irq);

    p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h0C) |=> $stable(mask));

endmodule

bind evt_aggr_top evt_aggr_chk #(
    .EV(EVENTS),
    .NL(NUM_LINES),
    .WW(WORD_W),
    .AW(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .bus_wr   (bus_wr_i),
    .bus_addr (bus_addr_i),
    .bus_wdata(bus_wdata_i),
    .irq      (irq_o),
    .status   (status_q),
    .mask     (mask_q),
    .pend_vld (pend_vld)
);

// File: tb/evt_aggr_top_tb_top.sv
module evt_aggr_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] evt_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [2:0]  irq_o;

    int n_chk = 0;
    int n_fail = 0;

    bit m_stat [96];
    bit m_mask [3][96];

    evt_aggr_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o),
        .irq_o      (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] one(input int i);
        logic [95:0] v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    function automatic bit m_line(input int g);
        for (int i = 0; i < 96; i++) if (m_stat[i] && m_mask[g][i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int hi = int'(a[7:4]);
        int w  = int'(a[3:2]);
        logic [31:0] r = '0;
        if (a[1:0] != 2'b00) return '0;
        if (hi == 0 && w < 3) begin
            for (int b = 0; b < 32; b++) r[b] = m_stat[w*32+b];
        end else if (hi >= 1 && hi <= 3 && w < 3) begin
            for (int b = 0; b < 32; b++) r[b] = m_mask[hi-1][w*32+b];
        end else if (hi == 4 && w < 3) begin
            for (int i = 0; i < 96; i++) begin
                if (m_stat[i] && m_mask[w][i]) begin
                    r = 32'h80 | 32'(i);
                    break;
                end
            end
        end
        return r;
    endfunction

    function automatic void m_step(input logic [95:0] ev, input bit wr,
                                   input logic [7:0] a, input logic [31:0] d);
        int hi = int'(a[7:4]);
        int w  = int'(a[3:2]);
        if (wr && a[1:0] == 2'b00) begin
            if (hi == 0 && w < 3) begin
                for (int b = 0; b < 32; b++) if (d[b]) m_stat[w*32+b] = 1'b0;
            end else if (hi >= 1 && hi <= 3 && w < 3) begin
                for (int b = 0; b < 32; b++) m_mask[hi-1][w*32+b] = d[b];
            end
        end
        for (int i = 0; i < 96; i++) if (ev[i]) m_stat[i] = 1'b1;
    endfunction

    // One clock: drive at the falling edge, optionally check a read,
    // advance the model at the rising edge, compare the lines afterwards.
    task automatic cyc(input logic [95:0] ev, input bit wr, input logic [7:0] a,
                       input logic [31:0] d, input bit do_rd, input string req);
        logic [2:0] exp_irq;
        evt_i = ev; bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = d;
        #1;
        if (do_rd && !wr) check(req, bus_rdata_o, m_read(a));
        @(posedge clk);
        m_step(ev, wr, a, d);
        @(negedge clk);
        evt_i = '0; bus_wr_i = 1'b0;
        for (int g = 0; g < 3; g++) exp_irq[g] = m_line(g);
        check({req, " irq"}, 32'(irq_o), 32'(exp_irq));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        cyc('0, 1'b1, a, d, 1'b0, req);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        cyc('0, 1'b0, a, '0, 1'b1, req);
    endtask

    task automatic pulse(input logic [95:0] ev, input string req);
        cyc(ev, 1'b0, 8'h00, '0, 1'b0, req);
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 20; k++) rd(8'(k*4), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 rdata in reset", bus_rdata_o, 32'h0);
        check("R1 irq in reset", 32'(irq_o), 32'h0);
        rst_n = 1'b1;
        read_all("R1 after reset");

        // R5: mask write and readback
        wr(8'h10, 32'hFFFF_FFFF, "R5");
        wr(8'h24, 32'h0000_00F0, "R5");
        wr(8'h38, 32'h8000_0001, "R5");
        rd(8'h10, "R5 mask A w0");
        rd(8'h24, "R5 mask B w1");
        rd(8'h38, "R5 mask C w2");

        // R2 / R6 / R8: capture, level and lowest index
        pulse(one(5), "R2 evt5");
        rd(8'h00, "R2 sticky");
        pulse(one(3), "R2 evt3");
        rd(8'h40, "R8 pend A=3");
        wr(8'h00, 32'h0000_0008, "R3 clear bit3");
        rd(8'h00, "R3 only bit3 cleared");
        rd(8'h40, "R8 pend A=5");

        // R7: event enabled only on B
        pulse(one(36), "R7 evt36");
        rd(8'h44, "R7 pend B=36");
        rd(8'h48, "R7 pend C none");

        // R4: set wins over same-cycle clear
        cyc(one(5), 1'b1, 8'h00, 32'h0000_0020, 1'b0, "R4 set+clear");
        rd(8'h00, "R4 bit5 kept");
        wr(8'h00, 32'h0000_0020, "R3 clear bit5");
        wr(8'h04, 32'hFFFF_FFFF, "R3 clear word1");
        rd(8'h40, "R8 pend A empty");

        // R6: masking drops the line while status stays
        pulse(one(64), "R6 evt64");
        rd(8'h48, "R8 pend C=64");
        wr(8'h38, 32'h0, "R6 mask off C");
        rd(8'h08, "R6 status retained");

        // R8: highest index, enabled on all lines
        wr(8'h18, 32'hFFFF_FFFF, "R8");
        wr(8'h28, 32'h8000_0000, "R8");
        wr(8'h38, 32'h8000_0000, "R8");
        wr(8'h08, 32'hFFFF_FFFF, "R3 clear word2");
        pulse(one(95), "R8 evt95");
        rd(8'h40, "R8 pend A=95");
        rd(8'h44, "R8 pend B=95");
        rd(8'h48, "R8 pend C=95");

        // R9: writes to unmapped, misaligned and pending addresses
        wr(8'h0C, 32'hFFFF_FFFF, "R9");
        wr(8'h11, 32'h0, "R9");
        wr(8'h40, 32'hFFFF_FFFF, "R9");
        wr(8'h4C, 32'hFFFF_FFFF, "R9");
        wr(8'h80, 32'hFFFF_FFFF, "R9");
        read_all("R9 nothing changed");
        rd(8'h13, "R9 misaligned read");
        rd(8'hF0, "R9 unmapped read");

        // Mixed traffic against the model (R6)
        for (int k = 0; k < 600; k++) begin
            logic [95:0] ev = '0;
            logic [7:0]  a  = 8'(($urandom % 20) * 4);
            if ($urandom % 3 == 0) ev[$urandom % 96] = 1'b1;
            if ($urandom % 4 == 0)
                cyc(ev, 1'b1, a, $urandom & $urandom, 1'b0, "R6 mixed");
            else
                cyc(ev, 1'b0, a, '0, 1'b1, "R6 mixed");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule